// File: doc/BRIEF.md
# Multi-Channel Edge-Positioned PWM Generator

This block drives up to sixteen PWM outputs from one shared timebase. A prescaler divides the input clock into step pulses, and a step counter counts through the period, wrapping at the programmed limit. Each channel has no duty-cycle setting. Instead it holds two step positions: the step where its output goes high and the step where it goes low. Placing the low position before the high position gives a high time that wraps across the period boundary. Setting both positions to the same step makes the output flip once per period. A position beyond the period never matches, which holds the output at a constant level.

Software configures the block through a simple byte-wide register bus with word-aligned offsets. Reads are combinational and return the settings currently in force. A build-time mask gives chosen channels a second, buffered copy of their edge positions. While the global synchronous-update bit is set, writes to those channels land in the buffer and move into the working copy only when the step counter wraps, so a period already under way finishes with the old edges.

Each channel is a two-state machine, LVL_LOW and LVL_HIGH. On a step pulse, RISE_HIT moves LVL_LOW to LVL_HIGH when the step being entered equals the high position. FALL_HIT moves LVL_HIGH to LVL_LOW when the step being entered equals the low position. On every other cycle the state holds.

Top module: `edgepwm_top`

## Requirements
- R1: After reset, every counter, enable, edge position and the sync bit read as zero, and every output is low.
- R2: A step pulse occurs once every (prescale+1) clocks. The step counter counts 0..period and wraps, so one PWM period lasts (prescale+1)*(period+1) clocks. If the prescale or period limit is lowered below the current count, that count wraps at its next opportunity.
- R3: On the step pulse that enters step N, an enabled channel goes high if N equals its rise position, and goes low if N equals its fall position. With rise < fall, the output is high for (fall-rise) steps per period.
- R4: With fall < rise, the high time wraps across the period boundary and lasts (period+1-rise+fall) steps.
- R5: With rise equal to fall, the output inverts once per period. This gives a 50% waveform whose period is twice the programmed one.
- R6: An edge position greater than the period never fires, so the channel holds a constant level.
- R7: Enable bits for channels 0-7 are at offset 0x08, and for channels 8-15 at offset 0x0C (bit = channel mod 8). A disabled channel drives its output low.
- R8: The offsets are: prescale 0x00, period 0x04, channel i rise 0x10+8i, channel i fall 0x14+8i, sync bit 0 at 0xE4. Any other offset reads zero, and writes to it change nothing.
- R9: Edge writes to a channel without a buffered copy take effect on the next clock, whatever the sync bit holds.
- R10: For a buffered channel with the sync bit set, an edge write is held back. Readback keeps returning the old position until the counter wraps, and then returns the new one.
- R11: For a buffered channel with the sync bit clear, an edge write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset for read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational readback of the offset on reg_addr |
| pwm_out | output | NCH | Channel outputs |

## Verification
The assertions assume that the write strobe is only ever a clean single-cycle pulse sampled at the clock edge. They also assume that reg_addr and reg_wdata are stable around that edge. The stimulus changes bus inputs only on the falling clock edge, so the design never sees them change at the sampling edge. The stimulus uses only channel indices below the channel count. It covers buffered and unbuffered channels, both settings of the sync bit, and period reductions made while the counter runs. A behavioural model follows the outputs and readback on every clock.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;

    typedef enum logic [0:0] {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int OFF_PSC    = 'h00;
    localparam int OFF_PER    = 'h04;
    localparam int OFF_EN_LO  = 'h08;
    localparam int OFF_EN_HI  = 'h0C;
    localparam int OFF_EDGE   = 'h10;
    localparam int EDGE_PITCH = 8;
    localparam int FALL_SKEW  = 4;
    localparam int OFF_SYNC   = 'hE4;

endpackage

// File: rtl/edgepwm_timebase.sv
module edgepwm_timebase #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] psc_i,
    input  logic [DW-1:0] per_i,
    output logic          tick_o,
    output logic          wrap_o,
    output logic [DW-1:0] nxt_o
);

    logic [DW-1:0] pre_q;
    logic [DW-1:0] stp_q;

    assign tick_o = (pre_q >= psc_i);
    assign wrap_o = tick_o && (stp_q >= per_i);
    assign nxt_o  = wrap_o ? '0 : stp_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            stp_q <= '0;
        end else begin
            pre_q <= tick_o ? '0 : pre_q + 1'b1;
            if (tick_o) begin
                stp_q <= nxt_o;
            end
        end
    end

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(stp_q));

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (stp_q == '0) && (pre_q == '0));

endmodule

// File: rtl/edgepwm_channel.sv
module edgepwm_channel
    import edgepwm_pkg::*;
#(
    parameter int DW       = 8,
    parameter bit SHADOWED = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wrap_i,
    input  logic [DW-1:0] nxt_i,
    input  logic          sync_i,
    input  logic          en_i,
    input  logic          we_rise_i,
    input  logic          we_fall_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rise_o,
    output logic [DW-1:0] fall_o,
    output logic          pwm_o
);

    logic [DW-1:0] cmp_rise;
    logic [DW-1:0] cmp_fall;
    lvl_e          st_q;
    lvl_e          st_d;

    generate
        if (SHADOWED) begin : g_buf
            logic [DW-1:0] buf_rise;
            logic [DW-1:0] buf_fall;
            logic          load;

            assign load     = wrap_i && sync_i;
            assign cmp_rise = load ? buf_rise : rise_o;
            assign cmp_fall = load ? buf_fall : fall_o;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    buf_rise <= '0;
                    buf_fall <= '0;
                    rise_o   <= '0;
                    fall_o   <= '0;
                end else begin
                    if (we_rise_i) buf_rise <= wdata_i;
                    if (we_fall_i) buf_fall <= wdata_i;
                    if (load) begin
                        rise_o <= buf_rise;
                        fall_o <= buf_fall;
                    end else if (!sync_i) begin
                        if (we_rise_i) rise_o <= wdata_i;
                        if (we_fall_i) fall_o <= wdata_i;
                    end
                end
            end

            // R10
            shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sync_i && !wrap_i) |=> ($stable(rise_o) && $stable(fall_o)));
        end else begin : g_direct
            assign cmp_rise = rise_o;
            assign cmp_fall = fall_o;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rise_o <= '0;
                    fall_o <= '0;
                end else begin
                    if (we_rise_i) rise_o <= wdata_i;
                    if (we_fall_i) fall_o <= wdata_i;
                end
            end

            // R9
            direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                we_rise_i |=> (rise_o == $past(wdata_i)));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            unique case (st_q)
                LVL_LOW:  if (nxt_i == cmp_rise) st_d = LVL_HIGH;
                LVL_HIGH: if (nxt_i == cmp_fall) st_d = LVL_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LVL_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pwm_o = en_i && (st_q == LVL_HIGH);
    end

    // R3
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q));

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !pwm_o);

endmodule

// File: rtl/edgepwm_top.sv
module edgepwm_top
    import edgepwm_pkg::*;
#(
    parameter int              NCH         = 16,
    parameter int              DW          = 8,
    parameter int              AW          = 8,
    parameter logic [NCH-1:0]  SHADOW_MASK = 16'h00F0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] pwm_out
);

    localparam int EN_BITS = 8;

    logic [DW-1:0]  psc_q;
    logic [DW-1:0]  per_q;
    logic           sync_q;
    logic [NCH-1:0] en_q;
    logic [15:0]    en_pad;
    logic           tick;
    logic           wrap;
    logic [DW-1:0]  nxt;
    logic [DW-1:0]  act_rise [NCH];
    logic [DW-1:0]  act_fall [NCH];

    assign en_pad = 16'(en_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q  <= '0;
            per_q  <= '0;
            sync_q <= 1'b0;
            en_q   <= '0;
        end else if (reg_we) begin
            if (reg_addr == AW'(OFF_PSC))  psc_q  <= reg_wdata;
            if (reg_addr == AW'(OFF_PER))  per_q  <= reg_wdata;
            if (reg_addr == AW'(OFF_SYNC)) sync_q <= reg_wdata[0];
            for (int i = 0; i < NCH; i++) begin
                if (reg_addr == AW'((i < EN_BITS) ? OFF_EN_LO : OFF_EN_HI)) begin
                    en_q[i] <= reg_wdata[i % EN_BITS];
                end
            end
        end
    end

    edgepwm_timebase #(.DW(DW)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .psc_i  (psc_q),
        .per_i  (per_q),
        .tick_o (tick),
        .wrap_o (wrap),
        .nxt_o  (nxt)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam int RISE_OFF = OFF_EDGE + EDGE_PITCH * g;
            localparam int FALL_OFF = RISE_OFF + FALL_SKEW;

            edgepwm_channel #(.DW(DW), .SHADOWED(SHADOW_MASK[g])) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick_i    (tick),
                .wrap_i    (wrap),
                .nxt_i     (nxt),
                .sync_i    (sync_q),
                .en_i      (en_q[g]),
                .we_rise_i (reg_we && (reg_addr == AW'(RISE_OFF))),
                .we_fall_i (reg_we && (reg_addr == AW'(FALL_OFF))),
                .wdata_i   (reg_wdata),
                .rise_o    (act_rise[g]),
                .fall_o    (act_fall[g]),
                .pwm_o     (pwm_out[g])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFF_PSC))   reg_rdata = psc_q;
        if (reg_addr == AW'(OFF_PER))   reg_rdata = per_q;
        if (reg_addr == AW'(OFF_EN_LO)) reg_rdata = DW'(en_pad[7:0]);
        if (reg_addr == AW'(OFF_EN_HI)) reg_rdata = DW'(en_pad[15:8]);
        if (reg_addr == AW'(OFF_SYNC))  reg_rdata = DW'(sync_q);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(OFF_EDGE + EDGE_PITCH * i))             reg_rdata = act_rise[i];
            if (reg_addr == AW'(OFF_EDGE + EDGE_PITCH * i + FALL_SKEW)) reg_rdata = act_fall[i];
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0));

    // R7
    upper_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(OFF_EN_LO)) |=> $stable(en_pad[15:8]));

endmodule

// File: tb/edgepwm_top_bench.sv
module edgepwm_top_bench;

    localparam int             NCH   = 16;
    localparam logic [15:0]    SMASK = 16'h00F0;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_we = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [7:0]     reg_wdata = '0;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] pwm_out;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    edgepwm_top #(.NCH(NCH), .DW(8), .AW(8), .SHADOW_MASK(SMASK)) u_edgepwm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    int m_psc, m_per, m_pre, m_stp, m_sync;
    int m_ra [NCH];
    int m_fa [NCH];
    int m_rs [NCH];
    int m_fs [NCH];
    bit m_lvl [NCH];
    bit m_en [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_psc = 0; m_per = 0; m_pre = 0; m_stp = 0; m_sync = 0;
            for (int c = 0; c < NCH; c++) begin
                m_ra[c] = 0; m_fa[c] = 0; m_rs[c] = 0; m_fs[c] = 0;
                m_lvl[c] = 0; m_en[c] = 0;
            end
        end else begin
            bit tk, wr, ld;
            int nx, cr, cf, osync, a, d;
            tk = (m_pre >= m_psc);
            wr = tk && (m_stp >= m_per);
            nx = wr ? 0 : m_stp + 1;
            osync = m_sync;
            for (int c = 0; c < NCH; c++) begin
                ld = wr && (osync != 0) && SMASK[c];
                cr = ld ? m_rs[c] : m_ra[c];
                cf = ld ? m_fs[c] : m_fa[c];
                if (tk) begin
                    if (nx == cr && nx == cf) m_lvl[c] = !m_lvl[c];
                    else if (nx == cr)        m_lvl[c] = 1;
                    else if (nx == cf)        m_lvl[c] = 0;
                end
                if (ld) begin
                    m_ra[c] = m_rs[c];
                    m_fa[c] = m_fs[c];
                end
            end
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) m_stp = nx;
            if (reg_we) begin
                a = int'(reg_addr);
                d = int'(reg_wdata);
                if (a == 'h00) m_psc = d;
                if (a == 'h04) m_per = d;
                if (a == 'hE4) m_sync = d & 1;
                for (int c = 0; c < NCH; c++) begin
                    if (c < 8 && a == 'h08) m_en[c] = d[c];
                    if (c >= 8 && a == 'h0C) m_en[c] = d[c - 8];
                    if (a == 'h10 + 8 * c) begin
                        m_rs[c] = d;
                        if (!(osync != 0 && SMASK[c])) m_ra[c] = d;
                    end
                    if (a == 'h14 + 8 * c) begin
                        m_fs[c] = d;
                        if (!(osync != 0 && SMASK[c])) m_fa[c] = d;
                    end
                end
            end
        end
    end

    function automatic int exp_rd(int a);
        int r;
        r = 0;
        if (a == 'h00) r = m_psc;
        if (a == 'h04) r = m_per;
        if (a == 'hE4) r = m_sync;
        for (int c = 0; c < NCH; c++) begin
            if (c < 8 && a == 'h08) r = r | (int'(m_en[c]) << c);
            if (c >= 8 && a == 'h0C) r = r | (int'(m_en[c]) << (c - 8));
            if (a == 'h10 + 8 * c) r = m_ra[c];
            if (a == 'h14 + 8 * c) r = m_fa[c];
        end
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_pwm();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_lvl[c] & m_en[c];
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk({cur_req, " pwm_out"}, int'(pwm_out), int'(exp_pwm()));
            chk({cur_req, " rdata"}, int'(reg_rdata), exp_rd(int'(reg_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 8'(a);
        reg_wdata = 8'(d);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        @(negedge clk);
        reg_addr = 8'(a);
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    task automatic count_high(int ch, int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            hi += int'(pwm_out[ch]);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        chk("R1 pwm_out", int'(pwm_out), 0);
        rd_chk("R1 psc", 'h00, 0);
        rd_chk("R1 per", 'h04, 0);
        rd_chk("R1 en_lo", 'h08, 0);
        rd_chk("R1 en_hi", 'h0C, 0);
        rd_chk("R1 rise5", 'h38, 0);
        rd_chk("R1 sync", 'hE4, 0);

        // R2 R3 R4 R5 R6: one period = 2*5 = 10 clocks
        cur_req = "R3";
        wr('h00, 1);
        wr('h04, 4);
        wr('h10, 0); wr('h14, 2);   // ch0 rise<fall
        wr('h18, 3); wr('h1C, 1);   // ch1 wrapped
        wr('h20, 2); wr('h24, 2);   // ch2 equal
        wr('h28, 7); wr('h2C, 1);   // ch3 rise never fires
        wr('h08, 'h0F);
        repeat (40) @(negedge clk);
        count_high(0, 100, hi);
        chk("R2 R3 ch0 high clocks per 100", hi, 40);
        cur_req = "R4";
        count_high(1, 100, hi);
        chk("R4 ch1 high clocks per 100", hi, 60);
        cur_req = "R5";
        count_high(2, 200, hi);
        chk("R5 ch2 high clocks per 200", hi, 100);
        cur_req = "R6";
        count_high(3, 100, hi);
        chk("R6 ch3 high clocks per 100", hi, 0);

        // R7: upper enable register, disable drives low
        cur_req = "R7";
        wr('h58, 1); wr('h5C, 3);   // ch9
        wr('h0C, 'h02);
        rd_chk("R7 en_hi", 'h0C, 2);
        repeat (30) @(negedge clk);
        wr('h08, 'h0E);
        repeat (12) @(negedge clk);
        count_high(0, 50, hi);
        chk("R7 ch0 disabled", hi, 0);

        // R8: unmapped offset
        cur_req = "R8";
        wr('h90, 'hFF);
        rd_chk("R8 unmapped read", 'h90, 0);
        rd_chk("R8 psc unchanged", 'h00, 1);
        rd_chk("R8 fall ch1", 'h1C, 1);

        // R10: buffered channel 5 with sync set
        cur_req = "R10";
        wr('h38, 1);                // sync=0: immediate
        wr('hE4, 1);
        wr('h38, 3);
        rd_chk("R10 old value held", 'h38, 1);
        repeat (25) @(negedge clk);
        rd_chk("R10 new value after wrap", 'h38, 3);

        // R9: unbuffered channel 0 with sync set
        cur_req = "R9";
        wr('h10, 5);
        rd_chk("R9 immediate", 'h10, 5);

        // R11: buffered channel 6 with sync clear
        cur_req = "R11";
        wr('hE4, 0);
        wr('h44, 8);
        rd_chk("R11 immediate", 'h44, 8);

        // R2: lower the period while the count is high
        cur_req = "R2";
        wr('h08, 'hFF);
        wr('h00, 0);
        wr('h04, 200);
        repeat (120) @(negedge clk);
        wr('h04, 10);
        repeat (60) @(negedge clk);
        wr('h04, 0);
        repeat (20) @(negedge clk);
        wr('h00, 3);
        wr('h04, 6);
        wr('hE4, 1);
        for (int k = 0; k < 8; k++) begin
            wr('h30 + 8 * k, k);
            repeat (k * 3) @(negedge clk);
        end
        repeat (200) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule